// File: doc/BRIEF.md
# Program Memory Byte Reader

This block fetches one byte from a program store that is organised in 16-bit words, while the pointer that software manipulates counts in bytes. The caller presents a 16-bit byte pointer together with a request, an access form and a destination register index. The block converts the pointer into a word address, takes one of the two byte lanes of the returned word, and hands the byte to the register file with a write strobe. For one of the forms it also returns the pointer advanced by one, so that a loop can step through a table.

A request takes three clock cycles. In the first cycle the word address goes to a synchronous memory with one cycle of read latency. In the second cycle the word arrives and the lane is chosen. In the third cycle the byte, its destination index and, when enabled, the updated pointer are presented. A new request may be accepted in that third cycle. If the finishing request advanced the pointer, the new request uses the advanced value and not the possibly stale pointer on its input. No status flag exists and none is affected.

Software that places a table at word address W reaches its first byte by loading the pointer with W shifted left by one.

Top module: `pm_byte_reader`

## Requirements
- R1: After reset the block is idle. `ready` is 1, and `mem_rd_en`, `wr_en` and `z_wr_en` are all 0.
- R2: In the cycle after a request is accepted (`req_valid` and `ready` both 1 at a rising edge), `mem_rd_en` is 1 and `mem_addr` equals the byte pointer shifted right by one. `mem_rd_en` is 0 in every other cycle.
- R3: Bit 0 of the pointer selects the byte lane. An even pointer returns bits 7:0 of the word and an odd pointer returns bits 15:8. A stored word 0x5876 yields 0x76 at the even address and 0x58 at the following address.
- R4: Form code 0 (implied) writes register index 0, whatever `req_dst` holds, and leaves the pointer unchanged (`z_wr_en` = 0).
- R5: Form code 1 (explicit) writes the register named by `req_dst`. `z_wr_en` is 0 and `z_out` equals the pointer that was used.
- R6: Form code 2 (post-increment) writes the register named by `req_dst`, asserts `z_wr_en` and gives `z_out` = pointer + 1. Code 3 behaves exactly like code 1.
- R7: A post-increment from 0xFFFF gives `z_out` = 0x0000.
- R8: `wr_en` is 1 for exactly one cycle, the third cycle after the accepting edge, and is 0 in the two cycles before it. `z_wr_en` is never 1 while `wr_en` is 0.
- R9: `ready` is 0 in the first and second cycles of a request. A request presented in those cycles is ignored and produces no later write.
- R10: A request accepted in the final cycle of a post-increment request uses the incremented pointer, not `z_in`.
- R11: A table at word address W is read by setting the pointer to W shifted left by one. With that pointer, `mem_addr` equals W and the low byte of word W is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_form | input | 2 | Access form: 0 implied, 1 explicit, 2 post-increment, 3 same as 1 |
| req_dst | input | 5 | Destination register index |
| z_in | input | 16 | Byte pointer from the register file |
| ready | output | 1 | Block can accept a request this cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Word address to memory |
| mem_rdata | input | 16 | Word returned one cycle after the strobe |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register index to write |
| wr_data | output | 8 | Selected byte |
| z_wr_en | output | 1 | Pointer update strobe |
| z_out | output | 16 | Pointer after the access |

## Verification
The write-back of one request and the acceptance of the next can occur in the same cycle. This case matters most when the finishing request advances the pointer. The bench provokes it by raising a new request during the write-back cycle of a post-increment read, with `z_in` still holding the old odd pointer. It then checks that the new request's word address and returned byte follow the advanced pointer. Because the advanced odd pointer moves to a new word, a design that took the stale input would show a different `mem_addr` and a different byte.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    typedef enum logic [1:0] {
        FORM_IMPLIED = 2'd0,
        FORM_EXPLICIT = 2'd1,
        FORM_POSTINC = 2'd2,
        FORM_ALIAS = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB = 2'd3
    } state_e;

    localparam int PMR_BYTE_W = 8;

    function automatic logic form_bumps(input form_e f);
        return f == FORM_POSTINC;
    endfunction

    function automatic logic form_implied(input form_e f);
        return f == FORM_IMPLIED;
    endfunction

endpackage

// File: rtl/pmr_seq.sv
module pmr_seq
    import pmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output state_e state,
    output logic   ready
);

    state_e state_q;
    state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  state_d = ST_WB;
            ST_WB:    state_d = start ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
    assign ready = (state_q == ST_IDLE) || (state_q == ST_WB);

endmodule

// File: rtl/pmr_lane_sel.sv
module pmr_lane_sel #(
    parameter int DATA_W    = 16,
    parameter int LANE_BITS = 1
) (
    input  logic [DATA_W-1:0]    word,
    input  logic [LANE_BITS-1:0] sel,
    output logic [7:0]           byte_o
);

    localparam int LANES = DATA_W / 8;

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*8 +: 8];
    end

    assign byte_o = lanes[sel];

endmodule

// File: rtl/pmr_zstep.sv
module pmr_zstep #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] z_cur,
    input  logic              bump,
    output logic [ADDR_W-1:0] z_next
);

    assign z_next = z_cur + {{(ADDR_W-1){1'b0}}, bump};

endmodule

// File: rtl/pm_byte_reader.sv
module pm_byte_reader
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5,
    localparam int LANE_BITS = $clog2(DATA_W / 8),
    localparam int WADDR_W   = ADDR_W - LANE_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_form,
    input  logic [IDX_W-1:0]   req_dst,
    input  logic [ADDR_W-1:0]  z_in,
    output logic               ready,
    output logic               mem_rd_en,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [7:0]         wr_data,
    output logic               z_wr_en,
    output logic [ADDR_W-1:0]  z_out
);

    state_e              state;
    logic                accept;
    form_e               form_q;
    logic [IDX_W-1:0]    dst_q;
    logic [ADDR_W-1:0]   z_q;
    logic [ADDR_W-1:0]   z_next;
    logic [ADDR_W-1:0]   z_src;
    logic [7:0]          lane_byte;
    logic [7:0]          byte_q;
    logic                fwd;

    assign accept = req_valid && ready;

    pmr_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (req_valid),
        .state (state),
        .ready (ready)
    );

    pmr_zstep #(.ADDR_W(ADDR_W)) u_zstep (
        .z_cur  (z_q),
        .bump   (form_bumps(form_q)),
        .z_next (z_next)
    );

    pmr_lane_sel #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_lane (
        .word   (mem_rdata),
        .sel    (z_q[LANE_BITS-1:0]),
        .byte_o (lane_byte)
    );

    // pointer advanced by the finishing request overrides the input copy
    assign fwd   = (state == ST_WB) && form_bumps(form_q);
    assign z_src = fwd ? z_next : z_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            form_q <= FORM_IMPLIED;
            dst_q  <= '0;
            z_q    <= '0;
            byte_q <= '0;
        end else begin
            if (accept) begin
                form_q <= form_e'(req_form);
                dst_q  <= req_dst;
                z_q    <= z_src;
            end
            if (state == ST_WAIT) begin
                byte_q <= lane_byte;
            end
        end
    end

    assign mem_rd_en = (state == ST_ISSUE);
    assign mem_addr  = z_q[ADDR_W-1:LANE_BITS];
    assign wr_en     = (state == ST_WB);
    assign wr_idx    = form_implied(form_q) ? '0 : dst_q;
    assign wr_data   = byte_q;
    assign z_wr_en   = wr_en && form_bumps(form_q);
    assign z_out     = z_next;

endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 5,
    parameter int WADDR_W = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         req_form,
    input logic [IDX_W-1:0]   req_dst,
    input logic [ADDR_W-1:0]  z_in,
    input logic               ready,
    input logic               mem_rd_en,
    input logic [WADDR_W-1:0] mem_addr,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               z_wr_en
);

    localparam int SH = ADDR_W - WADDR_W;

    p_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready && !z_wr_en) |=>
            (mem_rd_en && mem_addr == $past(z_in[ADDR_W-1:SH])));

    p_rd_busy_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !ready);

    p_wb_third_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> !wr_en ##1 !wr_en ##1 wr_en);

    p_zwe_in_wb_r8: assert property (@(posedge clk) disable iff (rst)
        z_wr_en |-> wr_en);

    p_ready_low_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> !ready ##1 !ready);

    p_dest_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (($past(req_form, 3) == 2'd0) ? (wr_idx == '0)
                                                  : (wr_idx == $past(req_dst, 3))));

    p_bump_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (z_wr_en == ($past(req_form, 3) == 2'd2)));

endmodule

bind pm_byte_reader pmr_checker #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .WADDR_W (WADDR_W)
) u_pmr_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_form  (req_form),
    .req_dst   (req_dst),
    .z_in      (z_in),
    .ready     (ready),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .z_wr_en   (z_wr_en)
);

// File: tb/pm_byte_reader_bench.sv
module pm_byte_reader_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_form = 2'd0;
    logic [4:0]  req_dst = 5'd0;
    logic [15:0] z_in = 16'd0;
    logic        ready;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [7:0]  wr_data;
    logic        z_wr_en;
    logic [15:0] z_out;

    logic [15:0] mem [256];
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pm_byte_reader u_pm_byte_reader (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_form  (req_form),
        .req_dst   (req_dst),
        .z_in      (z_in),
        .ready     (ready),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .z_wr_en   (z_wr_en),
        .z_out     (z_out)
    );

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [7:0] exp_byte(input logic [15:0] z);
        logic [15:0] w;
        w = mem[z[8:1]];
        return z[0] ? w[15:8] : w[7:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one complete access; ends at the negedge after write-back
    task automatic run_read(input logic [1:0] form, input logic [4:0] dst,
                            input logic [15:0] z, input logic [4:0] e_idx,
                            input logic e_bump, input logic [15:0] e_z);
        @(negedge clk);
        req_valid = 1'b1; req_form = form; req_dst = dst; z_in = z;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; z_in = 16'hBEEF;
        chk("R2 rd_en", mem_rd_en, 1);
        chk("R2 mem_addr", mem_addr, z[15:1]);
        chk("R8 wr_en c1", wr_en, 0);
        chk("R9 ready c1", ready, 0);
        @(negedge clk);
        chk("R8 wr_en c2", wr_en, 0);
        chk("R9 ready c2", ready, 0);
        chk("R2 rd_en c2", mem_rd_en, 0);
        @(negedge clk);
        chk("R8 wr_en c3", wr_en, 1);
        chk("R4/R5/R6 wr_idx", wr_idx, e_idx);
        chk("R3 wr_data", wr_data, exp_byte(z));
        chk("R6 z_wr_en", z_wr_en, e_bump);
        chk("R6/R7 z_out", z_out, e_z);
        @(negedge clk);
        chk("R8 wr_en after", wr_en, 0);
        chk("R8 z_wr_en after", z_wr_en, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready", ready, 1);
        chk("R1 rd_en", mem_rd_en, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 z_wr_en", z_wr_en, 0);
    endtask

    task automatic t_table;
        // table at word 0x40 holding 0x5876
        run_read(2'd1, 5'd16, 16'h0040 << 1, 5'd16, 1'b0, 16'h0080);
        chk("R11 low byte", exp_byte(16'h0080), 8'h76);
        run_read(2'd1, 5'd17, 16'h0081, 5'd17, 1'b0, 16'h0081);
        chk("R3 high byte", exp_byte(16'h0081), 8'h58);
    endtask

    task automatic t_implied;
        run_read(2'd0, 5'd21, 16'h0133, 5'd0, 1'b0, 16'h0133);
        run_read(2'd0, 5'd31, 16'h0002, 5'd0, 1'b0, 16'h0002);
    endtask

    task automatic t_explicit;
        run_read(2'd1, 5'd31, 16'h00A7, 5'd31, 1'b0, 16'h00A7);
        run_read(2'd3, 5'd5, 16'h0154, 5'd5, 1'b0, 16'h0154);
    endtask

    task automatic t_postinc;
        run_read(2'd2, 5'd12, 16'h0066, 5'd12, 1'b1, 16'h0067);
        run_read(2'd2, 5'd1, 16'h0067, 5'd1, 1'b1, 16'h0068);
    endtask

    task automatic t_wrap;
        run_read(2'd2, 5'd9, 16'hFFFF, 5'd9, 1'b1, 16'h0000);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        req_valid = 1'b1; req_form = 2'd1; req_dst = 5'd3; z_in = 16'h0010;
        @(posedge clk);
        @(negedge clk);
        req_form = 2'd2; req_dst = 5'd9; z_in = 16'h0033;
        chk("R9 ready low", ready, 0);
        @(negedge clk);
        chk("R9 ready low c2", ready, 0);
        chk("R9 no reissue", mem_rd_en, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 wr_idx kept", wr_idx, 5'd3);
        chk("R9 data kept", wr_data, exp_byte(16'h0010));
        chk("R9 no bump", z_wr_en, 0);
        @(negedge clk);
        chk("R9 no late rd", mem_rd_en, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no late write", wr_en, 0);
        end
    endtask

    task automatic t_backtoback;
        @(negedge clk);
        req_valid = 1'b1; req_form = 2'd2; req_dst = 5'd4; z_in = 16'h0121;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 first wb", wr_en, 1);
        chk("R10 first z_out", z_out, 16'h0122);
        chk("R10 ready in wb", ready, 1);
        req_valid = 1'b1; req_form = 2'd1; req_dst = 5'd7; z_in = 16'h0121;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 fwd addr", mem_addr, 16'h0122 >> 1);
        @(negedge clk);
        @(negedge clk);
        chk("R10 second wb", wr_en, 1);
        chk("R10 second idx", wr_idx, 5'd7);
        chk("R10 second data", wr_data, exp_byte(16'h0122));
        chk("R10 second z_out", z_out, 16'h0122);
        chk("R10 second no bump", z_wr_en, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
        end
        mem[8'h40] = 16'h5876;
        mem[8'h91] = 16'hC33C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_table();
        t_implied();
        t_explicit();
        t_postinc();
        t_wrap();
        t_ignore();
        t_backtoback();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule